// File: doc/BRIEF.md
# Wireless Link and Activity Indicator Controller

This block drives three active-low indicator lamps for a wireless network adapter. The first shows that the device has power. The second shows that a link exists. The third shows that frames are moving. The link and activity lamps do not glow steadily. They flash at a fixed rate of 10 Hz, driven by one shared prescaler. At the default 44 MHz clock, that prescaler flips a common blink phase every 2,200,000 cycles.

A link counts as up in two cases. The first is while the MAC reports a successful association with an access point. The second is while beacons keep arriving after the station has joined an ad-hoc network. Each beacon in that second case opens a window whose length, in clock cycles, comes from an input. Each transmit or receive strobe reloads an activity hold window, 100 ms by default, so that a single short frame still gives a visible flash.

The deepest power-down state blanks the activity lamp but leaves the link lamp working. All three lamps are dark while reset is applied.

Top module: `wlan_led_ctrl`

## Requirements
- R1: While rst_n is low, and on every cycle until the first rising clock edge after its release, led_pwr_n, led_link_n and led_act_n are all 1 (lamp off).
- R2: Out of reset, led_pwr_n is 0 exactly when pwr_on is 1. pwr_on acts at once, with no register in the path.
- R3: A shared blink phase starts at 0 after reset and inverts on every HALF_CYC-th rising edge. A qualified link or activity lamp is lit (0) only while the phase is 1 and is dark while it is 0.
- R4: While assoc_ok is 1, the link lamp is qualified, whatever the state of the beacon window.
- R5: A clock edge with beacon_rx=1 and ibss_joined=1 loads the beacon window with bcn_limit. The link lamp stays qualified for the bcn_limit edges that follow, counting the loading edge as the first. A new beacon restarts the window, and bcn_limit=0 opens no window.
- R6: An edge with ibss_joined=0 clears the beacon window, whatever beacon_rx is at that edge.
- R7: An edge with tx_frame=1 or rx_frame=1 loads the activity hold with ACT_HOLD. The activity lamp stays qualified for ACT_HOLD edges, counting the loading edge, and each new strobe restarts the hold.
- R8: While deep_sleep is 1, led_act_n is 1 and the activity hold keeps counting down. The link lamp is unaffected by deep_sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (44 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Device power is present |
| deep_sleep | input | 1 | Deepest low-power state is active |
| assoc_ok | input | 1 | Associated with an access point (level) |
| ibss_joined | input | 1 | Member of an ad-hoc network (level) |
| beacon_rx | input | 1 | One-cycle strobe: beacon received |
| bcn_limit | input | BCN_W | Beacon window length in cycles |
| tx_frame | input | 1 | One-cycle strobe: frame transmitted |
| rx_frame | input | 1 | One-cycle strobe: frame received |
| led_pwr_n | output | 1 | Power lamp drive, active low |
| led_link_n | output | 1 | Link lamp drive, active low |
| led_act_n | output | 1 | Activity lamp drive, active low |

## Verification
The hardest state to reach from the ports is a beacon window that expires, or is cut short, at an exact edge while the blink phase happens to be high. Only in that state does the lamp show the end of the window. The stimulus shortens HALF_CYC and ACT_HOLD and programs small bcn_limit values. It then places directed beacons, ibss_joined drops and bcn_limit=0 beacons at chosen offsets. Long random runs follow, in which beacon, frame and deep_sleep strobes land at every phase position. A cycle-level model in the bench predicts all three lamps on every cycle.

// File: rtl/wlan_led_ctrl.sv
module wlan_led_ctrl #(
  parameter int HALF_CYC = 2_200_000,
  parameter int ACT_HOLD = 4_400_000,
  parameter int BCN_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             deep_sleep,
  input  logic             assoc_ok,
  input  logic             ibss_joined,
  input  logic             beacon_rx,
  input  logic [BCN_W-1:0] bcn_limit,
  input  logic             tx_frame,
  input  logic             rx_frame,
  output logic             led_pwr_n,
  output logic             led_link_n,
  output logic             led_act_n
);
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int AW = $clog2(ACT_HOLD + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(HALF_CYC - 1);
  localparam logic [AW-1:0] ACT_LOAD = AW'(ACT_HOLD);

  logic          run;
  logic          phase;
  logic [PW-1:0] pre_cnt;
  logic [BCN_W-1:0] bcn_cnt;
  logic [AW-1:0] act_cnt;
  logic          frame_seen;
  logic          link_up;
  logic          act_up;

  assign frame_seen = tx_frame | rx_frame;
  assign link_up    = assoc_ok | (bcn_cnt != '0);
  assign act_up     = (act_cnt != '0) & ~deep_sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      phase   <= 1'b0;
    end else if (pre_cnt == PRE_LAST) begin
      pre_cnt <= '0;
      phase   <= ~phase;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     bcn_cnt <= '0;
    else if (!ibss_joined)          bcn_cnt <= '0;
    else if (beacon_rx)             bcn_cnt <= bcn_limit;
    else if (bcn_cnt != '0)         bcn_cnt <= bcn_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     act_cnt <= '0;
    else if (frame_seen)            act_cnt <= ACT_LOAD;
    else if (act_cnt != '0)         act_cnt <= act_cnt - 1'b1;
  end

  assign led_pwr_n  = ~(run & pwr_on);
  assign led_link_n = ~(run & link_up & phase);
  assign led_act_n  = ~(run & act_up & phase);

  // R2
  pwr_off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> led_pwr_n);

  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> ($past(pre_cnt) == PRE_LAST));

  // R5
  bcn_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beacon_rx && ibss_joined) |=> (bcn_cnt == $past(bcn_limit)));

  // R6
  bcn_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ibss_joined |=> (bcn_cnt == '0));

  // R7
  act_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_seen |=> (act_cnt == ACT_LOAD));

  // R8
  sleep_act_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep |-> led_act_n);
endmodule

// File: tb/wlan_led_ctrl_tb_top.sv
module wlan_led_ctrl_tb_top;
  localparam int HALF = 8;
  localparam int HOLD = 20;
  localparam int BW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b1, deep_sleep = 1'b0, assoc_ok = 1'b0, ibss_joined = 1'b0;
  logic beacon_rx = 1'b0, tx_frame = 1'b0, rx_frame = 1'b0;
  logic [BW-1:0] bcn_limit = '0;
  logic led_pwr_n, led_link_n, led_act_n;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  string ctx = "R1";

  always #2.5 clk = ~clk;

  wlan_led_ctrl #(.HALF_CYC(HALF), .ACT_HOLD(HOLD), .BCN_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .deep_sleep(deep_sleep),
    .assoc_ok(assoc_ok), .ibss_joined(ibss_joined), .beacon_rx(beacon_rx),
    .bcn_limit(bcn_limit), .tx_frame(tx_frame), .rx_frame(rx_frame),
    .led_pwr_n(led_pwr_n), .led_link_n(led_link_n), .led_act_n(led_act_n));

  // reference model
  bit m_run, m_phase;
  int m_pre, m_bcn, m_act;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_phase <= 0; m_pre <= 0; m_bcn <= 0; m_act <= 0;
    end else begin
      m_run <= 1;
      if (m_pre == HALF - 1) begin m_pre <= 0; m_phase <= !m_phase; end
      else m_pre <= m_pre + 1;
      if (!ibss_joined) m_bcn <= 0;
      else if (beacon_rx) m_bcn <= int'(bcn_limit);
      else if (m_bcn > 0) m_bcn <= m_bcn - 1;
      if (tx_frame || rx_frame) m_act <= HOLD;
      else if (m_act > 0) m_act <= m_act - 1;
    end
  end

  function automatic bit exp_pwr();
    return !(m_run && pwr_on);
  endfunction
  function automatic bit exp_link();
    return !(m_run && m_phase && (assoc_ok || m_bcn > 0));
  endfunction
  function automatic bit exp_act();
    return !(m_run && m_phase && m_act > 0 && !deep_sleep);
  endfunction

  task automatic cmp(input string tag, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s t=%0t actual=%0b expected=%0b", ctx, tag, $time, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    cmp("R2 pwr", led_pwr_n, exp_pwr());
    cmp("R4 link", led_link_n, exp_link());
    cmp("R7 act", led_act_n, exp_act());
  endtask

  task automatic run_for(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_beacon(input int lim);
    bcn_limit = BW'(lim); beacon_rx = 1; step(); beacon_rx = 0;
  endtask

  task automatic pulse_frame(input bit tx);
    if (tx) tx_frame = 1; else rx_frame = 1;
    step(); tx_frame = 0; rx_frame = 0;
  endtask

  initial begin
    void'($urandom(32'd7781));
    ctx = "R1";
    assoc_ok = 1; tx_frame = 1;
    run_for(4);
    if (led_pwr_n !== 1'b1 || led_link_n !== 1'b1 || led_act_n !== 1'b1) begin
      errors++;
      $display("FAIL R1 lamps during reset actual=%b%b%b expected=111",
               led_pwr_n, led_link_n, led_act_n);
    end
    vectors++;
    rst_n = 1; tx_frame = 0; assoc_ok = 0;
    ctx = "R3"; run_for(3 * HALF);
    ctx = "R4"; assoc_ok = 1; run_for(4 * HALF); assoc_ok = 0; run_for(HALF);
    ctx = "R5"; ibss_joined = 1;
    pulse_beacon(5); run_for(2 * HALF);
    pulse_beacon(HALF + 3); run_for(4); pulse_beacon(HALF + 3); run_for(3 * HALF);
    pulse_beacon(0); run_for(2 * HALF);
    pulse_beacon(1); run_for(HALF);
    ctx = "R6";
    pulse_beacon(40); run_for(HALF + 2); ibss_joined = 0; run_for(2 * HALF);
    ibss_joined = 1; run_for(2);
    bcn_limit = 30; ibss_joined = 0; beacon_rx = 1; step(); beacon_rx = 0;
    run_for(2 * HALF); ibss_joined = 1;
    ctx = "R7";
    pulse_frame(1); run_for(HOLD + HALF);
    pulse_frame(0); run_for(HOLD / 2); pulse_frame(1); run_for(HOLD + 2 * HALF);
    ctx = "R8";
    assoc_ok = 1; deep_sleep = 1; pulse_frame(0); run_for(HOLD / 2);
    deep_sleep = 0; run_for(HOLD); deep_sleep = 1; run_for(2 * HALF);
    deep_sleep = 0; assoc_ok = 0;
    ctx = "R2";
    pwr_on = 0; run_for(HALF); pwr_on = 1; run_for(3);
    ctx = "R3";
    for (int i = 0; i < 3000; i++) begin
      pwr_on      = ($urandom % 16) != 0;
      deep_sleep  = ($urandom % 8) == 0;
      if ($urandom % 40 == 0) assoc_ok = !assoc_ok;
      if ($urandom % 30 == 0) ibss_joined = !ibss_joined;
      beacon_rx   = ($urandom % 12) == 0;
      bcn_limit   = BW'($urandom % 24);
      tx_frame    = ($urandom % 25) == 0;
      rx_frame    = ($urandom % 25) == 0;
      step();
    end
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) @(negedge clk);
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule